// File: doc/BRIEF.md
# Legacy VGA Forwarding Decoder

This block sits beside the address decode of a two-port bus bridge and decides, for each transaction address phase, whether the transaction targets legacy VGA space and must be claimed and passed downstream. The decision does not use the bridge's ordinary base/limit windows. It covers the VGA frame buffer in memory space and the VGA register block in I/O space. It also covers a write-only palette snoop mode for a downstream graphics device that has to observe palette updates.

Each transaction is presented as a single-cycle address strobe carrying the address, a 2-bit command and the side the transaction came from. One clock later the block drives a forward flag and a claim (device select) flag. It also drives a flag that forces a frame-buffer read to a single non-prefetched transfer, and a 2-bit reason code. All of these hold until the next strobe. The two mode enables are sampled into registers every clock, and a decode uses the values captured at the previous edge.

Top module: `vga_fwd_decoder`

## Requirements
- R1: After active-low reset, and until a strobe is decoded, fwdOut, claimOut and singleXfer are 0 and reason is 00. Both captured enables are 0.
- R2: With VGA mode enabled, a memory command (cmd 00 read, 01 write) with address 0x000A0000 through 0x000BFFFF is forwarded and claimed with reason 01. Addresses 0x0009FFFF and 0x000C0000 are not forwarded.
- R3: With VGA mode enabled, an I/O command (cmd 10 read, 11 write) is forwarded and claimed with reason 10 when address bits 9:0 lie in 0x3B0–0x3BB or 0x3C0–0x3DF. Values 0x3BC and 0x3BF are not forwarded.
- R4: For every I/O decode, address bits 15:10 are ignored. Any nonzero value in bits 31:16 prevents a match.
- R5: singleXfer is 1 exactly when a memory read (cmd 00) is forwarded with reason 01. A forwarded memory write leaves it 0.
- R6: A transaction whose fromSecondary input is 1 is never forwarded or claimed, in any mode.
- R7: The region from 0x000C0000 upward (the VGA BIOS) is not decoded by VGA mode.
- R8: With only snoop enabled, an I/O write (cmd 11) whose bits 9:0 are 0x3C6, 0x3C8 or 0x3C9 is forwarded and claimed with reason 11. The R4 aliasing rules apply.
- R9: With only snoop enabled, I/O reads to the palette addresses, other I/O addresses such as 0x3C7, and all memory commands are not forwarded.
- R10: With both enables set, every result equals the VGA-mode-only result. A palette write therefore reports reason 10.
- R11: Outputs change only on the clock edge at which a strobe is sampled. They are visible after that edge and held unchanged while the strobe is low.
- R12: With both enables clear, no transaction is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addrStrobe | input | 1 | One-cycle address-phase strobe |
| addr | input | 32 | Transaction address |
| cmd | input | 2 | 00 mem read, 01 mem write, 10 I/O read, 11 I/O write |
| fromSecondary | input | 1 | 1 when the transaction started on the secondary side |
| vgaModeIn | input | 1 | VGA mode enable, captured every clock |
| snoopIn | input | 1 | Palette snoop enable, captured every clock |
| fwdOut | output | 1 | Forward downstream |
| claimOut | output | 1 | Device select / claim |
| singleXfer | output | 1 | Non-prefetchable single-transfer read |
| reason | output | 2 | 00 none, 01 VGA memory, 10 VGA I/O, 11 palette snoop |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address, a frame buffer of 0xA0000–0xBFFFF, 10 decoded I/O bits and a 64 KB I/O span. With these values, the exact range edges, the 1 KB aliases at 0x7C00 and 0xFC00, and the upper-zero rule (bit 16 set) can all be reached with literal addresses. A behavioural model, covering the mode precedence and the one-clock enable capture, is compared against the outputs on every clock.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'b00,
    CMD_MEM_WR = 2'b01,
    CMD_IO_RD  = 2'b10,
    CMD_IO_WR  = 2'b11
  } busCmd_e;

  typedef enum logic [1:0] {
    WHY_NONE  = 2'b00,
    WHY_MEM   = 2'b01,
    WHY_IO    = 2'b10,
    WHY_SNOOP = 2'b11
  } fwdReason_e;

  typedef struct packed {
    logic memHit;
    logic ioHit;
    logic palHit;
  } addrHits_t;

  typedef struct packed {
    logic       capture;
    logic       forward;
    logic       single;
    fwdReason_e reason;
  } ctrlStrobe_t;
endpackage

// File: rtl/vga_fwd_datapath.sv
module vga_fwd_datapath
  import vga_fwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IO_DEC_W  = 10,
  parameter int IO_SPAN_W = 16,
  parameter logic [ADDR_W-1:0] FB_LO = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] FB_HI = 32'h000B_FFFF,
  parameter int PAL_N = 3,
  parameter logic [PAL_N*IO_DEC_W-1:0] PAL_ADDRS = {10'h3C9, 10'h3C8, 10'h3C6}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  ctrlStrobe_t       ctrl,
  output addrHits_t         hits,
  output logic              fwdQ,
  output logic              claimQ,
  output logic              singleQ,
  output logic [1:0]        reasonQ
);
  localparam int UPPER_W = ADDR_W - IO_SPAN_W;
  localparam logic [IO_DEC_W-1:0] MONO_LO  = 10'h3B0;
  localparam logic [IO_DEC_W-1:0] MONO_HI  = 10'h3BB;
  localparam logic [IO_DEC_W-1:0] COLOR_LO = 10'h3C0;
  localparam logic [IO_DEC_W-1:0] COLOR_HI = 10'h3DF;

  logic [IO_DEC_W-1:0] ioLow;
  logic                upperZero;
  logic [PAL_N-1:0]    palMatch;

  assign ioLow     = addr[IO_DEC_W-1:0];
  assign upperZero = (addr[ADDR_W-1:IO_SPAN_W] == {UPPER_W{1'b0}});

  for (genvar i = 0; i < PAL_N; i++) begin : gPal
    assign palMatch[i] = (ioLow == PAL_ADDRS[i*IO_DEC_W +: IO_DEC_W]);
  end

  always_comb begin
    hits.memHit = (addr >= FB_LO) && (addr <= FB_HI);
    hits.ioHit  = upperZero &&
                  (((ioLow >= MONO_LO) && (ioLow <= MONO_HI)) ||
                   ((ioLow >= COLOR_LO) && (ioLow <= COLOR_HI)));
    hits.palHit = upperZero && (|palMatch);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdQ    <= 1'b0;
      claimQ  <= 1'b0;
      singleQ <= 1'b0;
      reasonQ <= 2'b00;
    end else if (ctrl.capture) begin
      fwdQ    <= ctrl.forward;
      claimQ  <= ctrl.forward;
      singleQ <= ctrl.single;
      reasonQ <= ctrl.reason;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(fwdQ) && $stable(reasonQ) && $stable(singleQ));
  assert_claim_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    claimQ == fwdQ);
  assert_single_memread_R5: assert property (@(posedge clk) disable iff (!rstN)
    singleQ |-> (fwdQ && reasonQ == 2'b01));
  assert_reason_coded_R2: assert property (@(posedge clk) disable iff (!rstN)
    fwdQ == (reasonQ != 2'b00));
endmodule

// File: rtl/vga_fwd_ctrl.sv
module vga_fwd_ctrl
  import vga_fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  logic [1:0]  cmd,
  input  logic        fromSecondary,
  input  logic        vgaModeIn,
  input  logic        snoopIn,
  input  addrHits_t   hits,
  output ctrlStrobe_t ctrl
);
  logic vgaModeQ, snoopQ;
  logic isIo, isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vgaModeQ <= 1'b0;
      snoopQ   <= 1'b0;
    end else begin
      vgaModeQ <= vgaModeIn;
      snoopQ   <= snoopIn;
    end
  end

  assign isIo    = cmd[1];
  assign isWrite = cmd[0];

  always_comb begin
    ctrl.capture = addrStrobe;
    ctrl.forward = 1'b0;
    ctrl.single  = 1'b0;
    ctrl.reason  = WHY_NONE;
    if (!fromSecondary) begin
      if (vgaModeQ) begin
        if (!isIo && hits.memHit) begin
          ctrl.forward = 1'b1;
          ctrl.reason  = WHY_MEM;
          ctrl.single  = !isWrite;
        end else if (isIo && hits.ioHit) begin
          ctrl.forward = 1'b1;
          ctrl.reason  = WHY_IO;
        end
      end else if (snoopQ && isIo && isWrite && hits.palHit) begin
        ctrl.forward = 1'b1;
        ctrl.reason  = WHY_SNOOP;
      end
    end
  end

  assert_secondary_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    fromSecondary |-> !ctrl.forward);
  assert_snoop_write_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.reason == WHY_SNOOP) |-> (cmd == CMD_IO_WR));
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
  import vga_fwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IO_DEC_W  = 10,
  parameter int IO_SPAN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStrobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cmd,
  input  logic              fromSecondary,
  input  logic              vgaModeIn,
  input  logic              snoopIn,
  output logic              fwdOut,
  output logic              claimOut,
  output logic              singleXfer,
  output logic [1:0]        reason
);
  addrHits_t   hits;
  ctrlStrobe_t ctrl;

  vga_fwd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .cmd(cmd),
    .fromSecondary(fromSecondary), .vgaModeIn(vgaModeIn), .snoopIn(snoopIn),
    .hits(hits), .ctrl(ctrl)
  );

  vga_fwd_datapath #(.ADDR_W(ADDR_W), .IO_DEC_W(IO_DEC_W), .IO_SPAN_W(IO_SPAN_W)) uDp (
    .clk(clk), .rstN(rstN), .addr(addr), .ctrl(ctrl), .hits(hits),
    .fwdQ(fwdOut), .claimQ(claimOut), .singleQ(singleXfer), .reasonQ(reason)
  );

  assert_secondary_no_claim_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && fromSecondary) |=> !claimOut);
  assert_both_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && !vgaModeIn && !snoopIn && $stable(vgaModeIn) && $stable(snoopIn)
     && $past(rstN)) |=> !fwdOut);
endmodule

// File: tb/vga_fwd_decoder_test.sv
`timescale 1ns/1ps
module vga_fwd_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStrobe = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  cmd = 2'b00;
  logic        fromSecondary = 1'b0;
  logic        vgaModeIn = 1'b0;
  logic        snoopIn = 1'b0;
  logic        fwdOut, claimOut, singleXfer;
  logic [1:0]  reason;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  vga_fwd_decoder uut (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .addr(addr), .cmd(cmd),
    .fromSecondary(fromSecondary), .vgaModeIn(vgaModeIn), .snoopIn(snoopIn),
    .fwdOut(fwdOut), .claimOut(claimOut), .singleXfer(singleXfer), .reason(reason)
  );

  // behavioural reference
  int mFwd = 0, mSingle = 0, mReason = 0, mVga = 0, mSnoop = 0;

  function automatic void refDecide(input logic [31:0] a, input int c, input int sec,
                                    input int vm, input int sn,
                                    output int f, output int s, output int r);
    int low;
    int upperOk;
    low = int'(a % 1024);
    upperOk = (a < 32'h10000);
    f = 0; s = 0; r = 0;
    if (sec != 0) return;
    if (vm != 0) begin
      if (c < 2 && a >= 32'hA0000 && a <= 32'hBFFFF) begin
        f = 1; r = 1; s = (c == 0);
      end else if (c >= 2 && upperOk &&
                   ((low >= 'h3B0 && low <= 'h3BB) || (low >= 'h3C0 && low <= 'h3DF))) begin
        f = 1; r = 2;
      end
    end else if (sn != 0 && c == 3 && upperOk &&
                 (low == 'h3C6 || low == 'h3C8 || low == 'h3C9)) begin
      f = 1; r = 3;
    end
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFwd = 0; mSingle = 0; mReason = 0; mVga = 0; mSnoop = 0;
    end else begin
      if (addrStrobe) refDecide(addr, int'(cmd), int'(fromSecondary), mVga, mSnoop,
                                mFwd, mSingle, mReason);
      mVga = int'(vgaModeIn);
      mSnoop = int'(snoopIn);
    end
  end

  // per-clock model comparison (R11 timing and hold)
  always @(negedge clk) begin
    if (rstN) begin
      testCount++;
      if (int'(fwdOut) != mFwd || int'(claimOut) != mFwd ||
          int'(singleXfer) != mSingle || int'(reason) != mReason) begin
        failCount++;
        $display("FAIL R11 model: got fwd=%0d claim=%0d single=%0d reason=%0d expected fwd=%0d single=%0d reason=%0d",
                 fwdOut, claimOut, singleXfer, reason, mFwd, mSingle, mReason);
      end
    end
  end

  task automatic expectOut(input int f, input int s, input int r, input string tag);
    testCount++;
    if (int'(fwdOut) != f || int'(claimOut) != f || int'(singleXfer) != s || int'(reason) != r) begin
      failCount++;
      $display("FAIL %s: got fwd=%0d claim=%0d single=%0d reason=%0d expected fwd=%0d single=%0d reason=%0d",
               tag, fwdOut, claimOut, singleXfer, reason, f, s, r);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] c, input logic sec,
                       input int f, input int s, input int r, input string tag);
    @(negedge clk);
    addr = a; cmd = c; fromSecondary = sec; addrStrobe = 1'b1;
    @(negedge clk);
    addrStrobe = 1'b0; fromSecondary = 1'b0;
    expectOut(f, s, r, tag);
  endtask

  task automatic setModes(input logic vm, input logic sn);
    @(negedge clk);
    vgaModeIn = vm; snoopIn = sn;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    vgaModeIn = 1'b1; snoopIn = 1'b1;
    repeat (3) @(negedge clk);
    expectOut(0, 0, 0, "R1 in reset");
    rstN = 1'b1;
    vgaModeIn = 1'b0; snoopIn = 1'b0;
    @(negedge clk);
    expectOut(0, 0, 0, "R1 after reset");

    // R12: nothing enabled
    probe(32'h000A0000, 2'b00, 1'b0, 0, 0, 0, "R12 mem off");
    probe(32'h000003C8, 2'b11, 1'b0, 0, 0, 0, "R12 io off");

    setModes(1'b1, 1'b0);
    probe(32'h000A0000, 2'b00, 1'b0, 1, 1, 1, "R2 R5 fb low read");
    probe(32'h000BFFFF, 2'b01, 1'b0, 1, 0, 1, "R2 R5 fb high write");
    probe(32'h0009FFFF, 2'b00, 1'b0, 0, 0, 0, "R2 below fb");
    probe(32'h000C0000, 2'b00, 1'b0, 0, 0, 0, "R7 bios");
    probe(32'h000C8000, 2'b01, 1'b0, 0, 0, 0, "R7 bios write");
    probe(32'h000003B0, 2'b10, 1'b0, 1, 0, 2, "R3 mono low");
    // hold while idle: change address, no strobe
    @(negedge clk); addr = 32'h0; cmd = 2'b00;
    @(negedge clk); expectOut(1, 0, 2, "R11 hold");
    probe(32'h000003BB, 2'b11, 1'b0, 1, 0, 2, "R3 mono high");
    probe(32'h000003BC, 2'b10, 1'b0, 0, 0, 0, "R3 gap");
    probe(32'h000003BF, 2'b10, 1'b0, 0, 0, 0, "R3 gap top");
    probe(32'h000003C0, 2'b10, 1'b0, 1, 0, 2, "R3 color low");
    probe(32'h000003DF, 2'b11, 1'b0, 1, 0, 2, "R3 color high");
    probe(32'h000003E0, 2'b10, 1'b0, 0, 0, 0, "R3 above color");
    probe(32'h00007FD4, 2'b10, 1'b0, 1, 0, 2, "R4 alias 0x7C00");
    probe(32'h0000FFB5, 2'b11, 1'b0, 1, 0, 2, "R4 alias 0xFC00");
    probe(32'h000103C0, 2'b10, 1'b0, 0, 0, 0, "R4 upper nonzero");
    probe(32'h000003C0, 2'b00, 1'b0, 0, 0, 0, "R3 mem cmd to io addr");
    probe(32'h000A0000, 2'b10, 1'b0, 0, 0, 0, "R2 io cmd to fb addr");
    probe(32'h000A1234, 2'b00, 1'b1, 0, 0, 0, "R6 secondary mem");
    probe(32'h000003C8, 2'b11, 1'b1, 0, 0, 0, "R6 secondary io");

    setModes(1'b0, 1'b1);
    probe(32'h000003C6, 2'b11, 1'b0, 1, 0, 3, "R8 palette 3C6");
    probe(32'h000003C8, 2'b11, 1'b0, 1, 0, 3, "R8 palette 3C8");
    probe(32'h0000F3C9, 2'b11, 1'b0, 1, 0, 3, "R8 palette alias 3C9");
    probe(32'h000103C9, 2'b11, 1'b0, 0, 0, 0, "R8 upper nonzero");
    probe(32'h000003C6, 2'b10, 1'b0, 0, 0, 0, "R9 read not claimed");
    probe(32'h000003C7, 2'b11, 1'b0, 0, 0, 0, "R9 non palette");
    probe(32'h000003B0, 2'b11, 1'b0, 0, 0, 0, "R9 mono not snooped");
    probe(32'h000A0000, 2'b01, 1'b0, 0, 0, 0, "R9 fb not snooped");
    probe(32'h000003C8, 2'b11, 1'b1, 0, 0, 0, "R6 secondary snoop");

    setModes(1'b1, 1'b1);
    probe(32'h000003C8, 2'b11, 1'b0, 1, 0, 2, "R10 palette as io");
    probe(32'h000003C6, 2'b10, 1'b0, 1, 0, 2, "R10 palette read");
    probe(32'h000B0000, 2'b00, 1'b0, 1, 1, 1, "R10 fb read");

    // enable capture latency: mode drop takes effect after one edge
    @(negedge clk);
    vgaModeIn = 1'b0; snoopIn = 1'b0;
    addr = 32'h000A0000; cmd = 2'b00; addrStrobe = 1'b1;
    @(negedge clk);
    addrStrobe = 1'b0;
    expectOut(1, 1, 1, "R11 enable captured previous edge");
    probe(32'h000A0000, 2'b00, 1'b0, 0, 0, 0, "R12 disabled again");

    rstN = 1'b0;
    @(negedge clk);
    expectOut(0, 0, 0, "R1 mid-run reset");
    rstN = 1'b1;
    probe(32'h000A0000, 2'b00, 1'b0, 0, 0, 0, "R1 enables cleared");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule